// File: doc/BRIEF.md
# SD Host Normal Interrupt Status Logic

This block keeps the normal (non-error) interrupt status word of an SD host controller. It samples level signals and single-cycle event pulses from the rest of the controller: card presence, buffer read and write availability, tuning command completion, DMA boundary and descriptor events, the data-line and write-transfer activity flags, and the card interrupt sources. On the edges that matter it sets sticky status bits. Software clears those bits by writing ones through a 16-bit write port with a strobe.

The card interrupt bit works differently. It is a level latch that software cannot clear by writing to it. It drops only when its status enable goes low, and it starts sampling again once the enable comes back. A select field picks the source of that latch: the DAT1 line or one of three dedicated interrupt pins.

Each status bit can latch only while its status enable bit is set. The single interrupt request is the OR of the status word masked by the signal enable word. Status bits 0, 1 and 9 to 15 always read as 0.

Top module: `sdh_irq_status`

## Requirements
- R1: Status bit 6 (insertion) sets on a 0-to-1 change of `card_present`. Status bit 7 (removal) sets on a 1-to-0 change of `card_present`. Both are visible one clock edge after the new level is sampled.
- R2: Status bit 5 (read buffer ready) sets on a 0-to-1 change of `rd_buf_en`. It also sets on every cycle in which `tune_cmd_done` is 1 while `tuning_active` is 1. A `tune_cmd_done` pulse with `tuning_active` at 0 does not set it.
- R3: Status bit 4 (write buffer ready) sets on a 0-to-1 change of `wr_buf_en`.
- R4: Status bit 3 (DMA) sets when `sdma_boundary` or `adma_desc_int` is 1, unless `xfer_done` is 1 in the same cycle or has been 1 since the last `xfer_start` pulse. A `xfer_start` in the same cycle as the DMA event re-arms it.
- R5: Status bit 2 (block gap) sets only while `gap_stop_req` is 1. With `xfer_is_read`=1 it sets on a falling edge of `dat_active`. With `xfer_is_read`=0 it sets on a falling edge of `wr_active`. The other flag's edge is ignored.
- R6: Status bit 8 (card interrupt) sets one edge after the selected source is 1 while `stat_en[8]` is 1. It stays set even after the source drops. Writing 1 to it has no effect. It reads 0 one edge after `stat_en[8]` is 0.
- R7: `irq_pin_sel`=0 selects `dat1_irq` as the card interrupt source. Values 1, 2 and 3 select `irq_pins[0]`, `irq_pins[1]` and `irq_pins[2]`. Values 4 to 7 select no source.
- R8: A write with `wr_en`=1 clears every status bit in 2..7 whose `wr_data` bit is 1, one edge later. If a set event hits the same bit in the same cycle, the bit stays 1.
- R9: A status bit in 2..7 does not set while its `stat_en` bit is 0. A bit that is already set stays set until it is cleared.
- R10: `irq` is 1 exactly when `status & sig_en` is non-zero, in the same cycle, with no register on the way.
- R11: After synchronous reset, `status` is 0 and `irq` is 0. Bits 0, 1 and 9 to 15 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| card_present | input | 1 | Debounced card-inserted level |
| rd_buf_en | input | 1 | Read buffer has data available |
| wr_buf_en | input | 1 | Write buffer has space available |
| tuning_active | input | 1 | Tuning procedure is running |
| tune_cmd_done | input | 1 | Pulse: one tuning command finished |
| sdma_boundary | input | 1 | Pulse: SDMA buffer boundary reached |
| adma_desc_int | input | 1 | Pulse: ADMA descriptor with interrupt flag |
| xfer_done | input | 1 | Pulse: transfer complete |
| xfer_start | input | 1 | Pulse: new transfer begins |
| gap_stop_req | input | 1 | Stop-at-block-gap request level |
| xfer_is_read | input | 1 | 1 = current transfer is a read |
| dat_active | input | 1 | Data line active level |
| wr_active | input | 1 | Write transfer active level |
| dat1_irq | input | 1 | Card interrupt seen on DAT1, active high |
| irq_pins | input | 3 | Dedicated card interrupt pins, active high |
| irq_pin_sel | input | 3 | Card interrupt source select |
| stat_en | input | 16 | Per-bit status enable |
| sig_en | input | 16 | Per-bit interrupt signal enable |
| wr_en | input | 1 | Write-one-to-clear strobe |
| wr_data | input | 16 | Write-one-to-clear data |
| status | output | 16 | Interrupt status word |
| irq | output | 1 | Interrupt request to host |

## Verification
Every status bit, the card interrupt latch included, changes at the first rising edge that samples its trigger. This covers a level edge against the previous sample, an event pulse, a clear write and an enable drop. The `irq` output follows `status` and `sig_en` with no delay.

The bench drives inputs just after a falling edge. A behavioural model updates on the rising edge from the same inputs. Both `status` and `irq` are compared 1 ns after the next falling edge, so that edge's new inputs have already settled into `irq`. The directed checks step exactly one rising edge after each stimulus. The `irq` checks take no step after changing `sig_en`.

// File: rtl/sdh_irq_pkg.sv
// Package: shared bit positions for the SD host normal interrupt status word
// and the index map of the sampled level inputs. Assumes a 16-bit status word.
package sdh_irq_pkg;
    localparam int BIT_GAP  = 2;
    localparam int BIT_DMA  = 3;
    localparam int BIT_BWR  = 4;
    localparam int BIT_BRD  = 5;
    localparam int BIT_INS  = 6;
    localparam int BIT_REM  = 7;
    localparam int BIT_CARD = 8;

    localparam int E_CARD = 0;
    localparam int E_RD   = 1;
    localparam int E_WR   = 2;
    localparam int E_DAT  = 3;
    localparam int E_WACT = 4;
    localparam int EDGE_N = 5;
endpackage

// File: rtl/sdh_edge_det.sv
// Module: sdh_edge_det
// Registers each input bit once and reports rising and falling edges as the
// difference between the current input and the previous sample.
// Assumes inputs are synchronous to clk. The previous sample resets to 0.
module sdh_edge_det #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sig_i,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);
    logic [N-1:0] prev_q;

    // hold last sampled value of every input
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sig_i;
    end

    for (genvar i = 0; i < N; i++) begin : g_edge
        assign rise_o[i] =  sig_i[i] & ~prev_q[i];
        assign fall_o[i] = ~sig_i[i] &  prev_q[i];
    end

    // R1
    edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_o != '0) |=> (prev_q & $past(rise_o)) == $past(rise_o));
endmodule

// File: rtl/sdh_dma_qual.sv
// Module: sdh_dma_qual
// Qualifies DMA interrupt events. Once a transfer-complete pulse is seen, DMA
// events are blocked until a new transfer starts.
// Assumes xfer_done wins over xfer_start when both pulse together.
module sdh_dma_qual (
    input  logic clk,
    input  logic rst_n,
    input  logic sdma_i,
    input  logic adma_i,
    input  logic done_i,
    input  logic start_i,
    output logic evt_o
);
    logic done_seen_q;
    logic blocked;

    // remember that the current transfer has completed
    always_ff @(posedge clk) begin
        if (!rst_n)       done_seen_q <= 1'b0;
        else if (done_i)  done_seen_q <= 1'b1;
        else if (start_i) done_seen_q <= 1'b0;
    end

    // block events after completion; a new start re-arms at once
    always_comb begin
        blocked = done_i | (done_seen_q & ~start_i);
        evt_o   = (sdma_i | adma_i) & ~blocked;
    end

    // R4
    done_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> done_seen_q);
endmodule

// File: rtl/sdh_card_irq.sv
// Module: sdh_card_irq
// Picks the card interrupt source (DAT1 or one of PIN_N dedicated pins) and
// latches it at level while enabled. Dropping the enable clears the latch.
// Assumes active-high, already synchronised sources. Select 0 means DAT1.
module sdh_card_irq #(
    parameter int PIN_N = 3,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dat1_i,
    input  logic [PIN_N-1:0] pins_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             en_i,
    output logic             latch_o
);
    logic src;
    logic lat_q;

    // decode the selected interrupt source; unused codes give 0
    always_comb begin
        src = 1'b0;
        if (sel_i == '0) src = dat1_i;
        for (int k = 0; k < PIN_N; k++) begin
            if (sel_i == SEL_W'(k + 1)) src = pins_i[k];
        end
    end

    // level latch, cleared only by removing the enable
    always_ff @(posedge clk) begin
        if (!rst_n)     lat_q <= 1'b0;
        else if (!en_i) lat_q <= 1'b0;
        else if (src)   lat_q <= 1'b1;
    end

    assign latch_o = lat_q;

    // R6
    card_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && latch_o) |=> latch_o);
    // R6
    card_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !latch_o);
endmodule

// File: rtl/sdh_irq_status.sv
// Module: sdh_irq_status (top)
// Normal interrupt status word of an SD host controller. It collects edge and
// pulse events into sticky write-one-to-clear bits 2..7, adds a read-only
// level-latched card interrupt at bit 8 and drives one masked interrupt request.
// Assumes all inputs are synchronous to clk. A set event beats a clear on the
// same bit.
module sdh_irq_status
    import sdh_irq_pkg::*;
#(
    parameter int ST_W  = 16,
    parameter int PIN_N = 3,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             card_present,
    input  logic             rd_buf_en,
    input  logic             wr_buf_en,
    input  logic             tuning_active,
    input  logic             tune_cmd_done,
    input  logic             sdma_boundary,
    input  logic             adma_desc_int,
    input  logic             xfer_done,
    input  logic             xfer_start,
    input  logic             gap_stop_req,
    input  logic             xfer_is_read,
    input  logic             dat_active,
    input  logic             wr_active,
    input  logic             dat1_irq,
    input  logic [PIN_N-1:0] irq_pins,
    input  logic [SEL_W-1:0] irq_pin_sel,
    input  logic [ST_W-1:0]  stat_en,
    input  logic [ST_W-1:0]  sig_en,
    input  logic             wr_en,
    input  logic [ST_W-1:0]  wr_data,
    output logic [ST_W-1:0]  status,
    output logic             irq
);
    localparam logic [ST_W-1:0] W1C_MASK =
        ST_W'(((1 << (BIT_REM + 1)) - 1) & ~((1 << BIT_GAP) - 1));

    logic [EDGE_N-1:0] lvl_in, lvl_rise, lvl_fall;
    logic [ST_W-1:0]   set_raw, set_gated, clr_vec, ev_q;
    logic              dma_evt, card_lat, gap_edge;

    assign lvl_in = {wr_active, dat_active, wr_buf_en, rd_buf_en, card_present};

    sdh_edge_det #(.N(EDGE_N)) u_edge (
        .clk(clk), .rst_n(rst_n), .sig_i(lvl_in),
        .rise_o(lvl_rise), .fall_o(lvl_fall)
    );

    sdh_dma_qual u_dma (
        .clk(clk), .rst_n(rst_n), .sdma_i(sdma_boundary), .adma_i(adma_desc_int),
        .done_i(xfer_done), .start_i(xfer_start), .evt_o(dma_evt)
    );

    sdh_card_irq #(.PIN_N(PIN_N), .SEL_W(SEL_W)) u_card (
        .clk(clk), .rst_n(rst_n), .dat1_i(dat1_irq), .pins_i(irq_pins),
        .sel_i(irq_pin_sel), .en_i(stat_en[BIT_CARD]), .latch_o(card_lat)
    );

    // gather the raw set events for each sticky bit
    always_comb begin
        gap_edge = gap_stop_req &
                   (xfer_is_read ? lvl_fall[E_DAT] : lvl_fall[E_WACT]);
        set_raw           = '0;
        set_raw[BIT_INS]  = lvl_rise[E_CARD];
        set_raw[BIT_REM]  = lvl_fall[E_CARD];
        set_raw[BIT_BRD]  = lvl_rise[E_RD] | (tuning_active & tune_cmd_done);
        set_raw[BIT_BWR]  = lvl_rise[E_WR];
        set_raw[BIT_DMA]  = dma_evt;
        set_raw[BIT_GAP]  = gap_edge;
        set_gated = set_raw & stat_en & W1C_MASK;
        clr_vec   = (wr_en ? wr_data : '0) & W1C_MASK;
    end

    // sticky bits: clear by write-one, set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n) ev_q <= '0;
        else        ev_q <= ((ev_q & ~clr_vec) | set_gated) & W1C_MASK;
    end

    // merge the card interrupt latch and drive the request
    always_comb begin
        status = ev_q | (ST_W'(card_lat) << BIT_CARD);
        irq    = |(status & sig_en);
    end

    // R1
    ins_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_en[BIT_INS] && lvl_rise[E_CARD]) |=> status[BIT_INS]);
    // R4
    dma_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && !status[BIT_DMA]) |=> !status[BIT_DMA]);
    // R5
    gap_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!gap_stop_req && !status[BIT_GAP]) |=> !status[BIT_GAP]);
    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[BIT_BWR] && stat_en[BIT_BWR] && lvl_rise[E_WR])
        |=> status[BIT_BWR]);
    // R10
    no_sig_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sig_en == '0) |-> !irq);
endmodule

// File: tb/sim_sdh_irq_status.sv
`timescale 1ns/1ps
module sim_sdh_irq_status;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic card_present = 0, rd_buf_en = 0, wr_buf_en = 0, tuning_active = 0;
    logic tune_cmd_done = 0, sdma_boundary = 0, adma_desc_int = 0;
    logic xfer_done = 0, xfer_start = 0, gap_stop_req = 0, xfer_is_read = 0;
    logic dat_active = 0, wr_active = 0, dat1_irq = 0, wr_en = 0;
    logic [2:0]  irq_pins = 0, irq_pin_sel = 0;
    logic [15:0] stat_en = 16'hFFFF, sig_en = 0, wr_data = 0;
    logic [15:0] status;
    logic        irq;

    int nchk = 0, nerr = 0;
    bit cmp_on = 0;

    always #2.5 clk = ~clk;

    sdh_irq_status u0 (
        .clk(clk), .rst_n(rst_n), .card_present(card_present), .rd_buf_en(rd_buf_en),
        .wr_buf_en(wr_buf_en), .tuning_active(tuning_active), .tune_cmd_done(tune_cmd_done),
        .sdma_boundary(sdma_boundary), .adma_desc_int(adma_desc_int), .xfer_done(xfer_done),
        .xfer_start(xfer_start), .gap_stop_req(gap_stop_req), .xfer_is_read(xfer_is_read),
        .dat_active(dat_active), .wr_active(wr_active), .dat1_irq(dat1_irq),
        .irq_pins(irq_pins), .irq_pin_sel(irq_pin_sel), .stat_en(stat_en), .sig_en(sig_en),
        .wr_en(wr_en), .wr_data(wr_data), .status(status), .irq(irq)
    );

    // behavioural reference model, advanced on every rising edge
    logic [15:0] m_stat = 0;
    bit p_card = 0, p_rd = 0, p_wr = 0, p_dat = 0, p_wa = 0, m_done = 0;
    always @(posedge clk) begin
        logic [15:0] setv, clr;
        bit blk, src;
        if (!rst_n) begin
            m_stat = 0; p_card = 0; p_rd = 0; p_wr = 0; p_dat = 0; p_wa = 0; m_done = 0;
        end else begin
            setv = 0;
            setv[6] = card_present && !p_card;
            setv[7] = !card_present && p_card;
            setv[5] = (rd_buf_en && !p_rd) || (tuning_active && tune_cmd_done);
            setv[4] = wr_buf_en && !p_wr;
            blk = xfer_done || (m_done && !xfer_start);
            setv[3] = (sdma_boundary || adma_desc_int) && !blk;
            setv[2] = gap_stop_req &&
                      (xfer_is_read ? (p_dat && !dat_active) : (p_wa && !wr_active));
            setv = setv & stat_en;
            clr = wr_en ? wr_data : 16'h0;
            for (int b = 2; b <= 7; b++)
                m_stat[b] = (m_stat[b] && !clr[b]) || setv[b];
            case (irq_pin_sel)
                3'd0: src = dat1_irq;
                3'd1: src = irq_pins[0];
                3'd2: src = irq_pins[1];
                3'd3: src = irq_pins[2];
                default: src = 0;
            endcase
            m_stat[8] = stat_en[8] ? (m_stat[8] || src) : 1'b0;
            if (xfer_done) m_done = 1; else if (xfer_start) m_done = 0;
            p_card = card_present; p_rd = rd_buf_en; p_wr = wr_buf_en;
            p_dat = dat_active; p_wa = wr_active;
        end
    end

    function automatic string tag_of(int b);
        case (b)
            2: return "R5";  3: return "R4";  4: return "R3";  5: return "R2";
            6, 7: return "R1";  8: return "R6/R7";
            default: return "R11";
        endcase
    endfunction

    // every-cycle comparison against the model, 1 ns after the falling edge
    always @(negedge clk) begin
        #1;
        if (cmp_on) begin
            nchk++;
            if (status !== m_stat) begin
                nerr++;
                for (int b = 0; b < 16; b++)
                    if (status[b] !== m_stat[b]) begin
                        $display("FAIL %s cycle compare: status actual=%h expected=%h (bit %0d)",
                                 tag_of(b), status, m_stat, b);
                        break;
                    end
            end
            nchk++;
            if (irq !== (|(m_stat & sig_en))) begin
                nerr++;
                $display("FAIL R10 cycle compare: irq actual=%0b expected=%0b",
                         irq, |(m_stat & sig_en));
            end
        end
    end

    task automatic step();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic expect_bit(int idx, bit exp, string tag);
        #1;
        nchk++;
        if (status[idx] !== exp) begin
            nerr++;
            $display("FAIL %s: status[%0d] actual=%0b expected=%0b", tag, idx, status[idx], exp);
        end
    endtask

    task automatic expect_irq(bit exp, string tag);
        #1;
        nchk++;
        if (irq !== exp) begin
            nerr++;
            $display("FAIL %s: irq actual=%0b expected=%0b", tag, irq, exp);
        end
    endtask

    task automatic clear_bits(logic [15:0] m);
        wr_en = 1; wr_data = m; step(); wr_en = 0; wr_data = 0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R11: reset state
        #1; nchk++;
        if (status !== 16'h0 || irq !== 1'b0) begin
            nerr++;
            $display("FAIL R11: status actual=%h expected=0000 irq actual=%0b expected=0", status, irq);
        end
        @(negedge clk);
        cmp_on = 1;

        // R1: insertion and removal edges
        card_present = 1; step(); expect_bit(6, 1, "R1 insert");
        card_present = 0; step(); expect_bit(7, 1, "R1 remove");
        // R8: write-one-to-clear
        clear_bits(16'h00C0); expect_bit(6, 0, "R8 clear"); expect_bit(7, 0, "R8 clear");
        // R8: set beats clear; R3 rise sets bit 4
        wr_buf_en = 1; wr_en = 1; wr_data = 16'h0010; step(); wr_en = 0; wr_data = 0;
        expect_bit(4, 1, "R8 set wins");
        clear_bits(16'h0010); expect_bit(4, 0, "R3 cleared");
        wr_buf_en = 0; step(); wr_buf_en = 1; step(); expect_bit(4, 1, "R3 rise");
        clear_bits(16'h0010);
        // R9: disabled status does not latch
        stat_en[5] = 0; rd_buf_en = 1; step(); expect_bit(5, 0, "R9 gated");
        stat_en = 16'hFFFF; step(); expect_bit(5, 0, "R9 no late set");
        // R2: tuning pulses
        tuning_active = 1; tune_cmd_done = 1; step(); tune_cmd_done = 0;
        expect_bit(5, 1, "R2 tuning");
        clear_bits(16'h0020); expect_bit(5, 0, "R2 cleared");
        tune_cmd_done = 1; step(); tune_cmd_done = 0; expect_bit(5, 1, "R2 second tuning");
        clear_bits(16'h0020);
        tuning_active = 0; tune_cmd_done = 1; step(); tune_cmd_done = 0;
        expect_bit(5, 0, "R2 no tuning");
        // R4: DMA and its completion guard
        sdma_boundary = 1; step(); sdma_boundary = 0; expect_bit(3, 1, "R4 sdma");
        clear_bits(16'h0008);
        xfer_done = 1; step(); xfer_done = 0;
        sdma_boundary = 1; step(); sdma_boundary = 0; expect_bit(3, 0, "R4 after done");
        adma_desc_int = 1; step(); expect_bit(3, 0, "R4 adma after done");
        xfer_start = 1; step(); xfer_start = 0; adma_desc_int = 0;
        expect_bit(3, 1, "R4 rearmed");
        clear_bits(16'h0008);
        // R5: block gap
        dat_active = 1; step(); dat_active = 0; step(); expect_bit(2, 0, "R5 no request");
        gap_stop_req = 1; xfer_is_read = 1; dat_active = 1; step(); dat_active = 0; step();
        expect_bit(2, 1, "R5 read gap");
        clear_bits(16'h0004);
        xfer_is_read = 0; wr_active = 1; step(); wr_active = 0; step();
        expect_bit(2, 1, "R5 write gap");
        clear_bits(16'h0004);
        dat_active = 1; step(); dat_active = 0; step(); expect_bit(2, 0, "R5 wrong flag");
        gap_stop_req = 0;
        // R6: card interrupt latch
        irq_pin_sel = 0; dat1_irq = 1; step(); expect_bit(8, 1, "R6 latch");
        dat1_irq = 0; step(); expect_bit(8, 1, "R6 holds");
        clear_bits(16'h0100); expect_bit(8, 1, "R6 read-only");
        // R10: irq masking, no step needed
        sig_en = 16'h0000; expect_irq(0, "R10 masked");
        sig_en = 16'h0100; expect_irq(1, "R10 enabled");
        sig_en = 16'h0000;
        stat_en[8] = 0; step(); expect_bit(8, 0, "R6 enable drop");
        stat_en[8] = 1; step(); expect_bit(8, 0, "R6 resumed idle");
        // R7: source select
        irq_pin_sel = 2; irq_pins = 3'b010; step(); expect_bit(8, 1, "R7 pin B");
        irq_pins = 0; stat_en[8] = 0; step(); stat_en[8] = 1;
        irq_pin_sel = 5; irq_pins = 3'b111; dat1_irq = 1; step(); expect_bit(8, 0, "R7 unused code");
        irq_pin_sel = 1; irq_pins = 3'b110; dat1_irq = 0; step(); expect_bit(8, 0, "R7 pin A low");
        irq_pins = 3'b001; step(); expect_bit(8, 1, "R7 pin A high");
        irq_pins = 0;

        // random phase, checked by the cycle comparison
        for (int c = 0; c < 3000; c++) begin
            card_present  = ($urandom % 8 == 0) ? ~card_present : card_present;
            rd_buf_en     = $urandom % 2;  wr_buf_en = $urandom % 2;
            tuning_active = $urandom % 2;  tune_cmd_done = ($urandom % 4 == 0);
            sdma_boundary = ($urandom % 6 == 0); adma_desc_int = ($urandom % 6 == 0);
            xfer_done     = ($urandom % 8 == 0); xfer_start = ($urandom % 8 == 0);
            gap_stop_req  = $urandom % 2;  xfer_is_read = $urandom % 2;
            dat_active    = $urandom % 2;  wr_active = $urandom % 2;
            dat1_irq      = ($urandom % 5 == 0); irq_pins = 3'($urandom);
            irq_pin_sel   = 3'($urandom);
            stat_en       = ($urandom % 8 == 0) ? 16'($urandom) : 16'hFFFF;
            sig_en        = 16'($urandom);
            wr_en         = ($urandom % 4 == 0); wr_data = 16'($urandom);
            step();
        end
        summary();
    end
endmodule